// File: doc/BRIEF.md
# Mailbox-Driven I2C Master

This block is a single-channel I2C master that software drives through four 16-bit registers. Software first places up to two payload bytes in a write mailbox. It then writes a command word that names the 7-bit target, the direction, the payload length, an address-only probe flag and a flag that keeps the bus. Writing the command starts the transfer. The controller generates START, the address byte, the data bytes and the acknowledge slots on open-drain SCL and SDA. It then either issues STOP or leaves SCL low so that the next command opens with a repeated START. Longer transactions are built by chaining several commands this way.

When a transfer ends, the controller sets one sticky event bit: transmit-done, receive-done or error. Software clears these bits by writing ones to them. Received bytes are returned in a read mailbox. The SCL rate comes from a quarter-period divider parameter. A target that holds SCL low stalls the master until it releases the line.

Register map (2-bit address): 0 = command word (a read returns the last accepted command), 1 = status, 2 = write mailbox, 3 = read mailbox.

Top module: `i2c_mbox_master`

## Requirements
- R1: A command write executes only when command bits 15:14 equal binary 10 and no transfer is in flight. Any other command write is ignored: busy stays clear, no event is set and no START appears on the bus.
- R2: Status bit 0 (busy) reads 1 from the cycle after an accepted command write. It clears on the same clock edge that sets exactly one event bit.
- R3: The first byte on the bus is command bits 6:0 followed by the R/W bit. The R/W bit is 0 when command bit 10 (write) is set and 1 when it is clear.
- R4: A write command sends write-mailbox bits 7:0. If command bit 11 is set, it then sends bits 15:8. A fully acknowledged write sets status bit 14.
- R5: A read command takes in one byte, or two when bit 11 is set. The first byte goes to read-mailbox bits 7:0 and the second to bits 15:8. The master ACKs every byte except the last, which it NACKs. A completed read sets status bit 15.
- R6: With command bit 12 set, only the address byte is sent (a presence probe). An acknowledged probe sets the event for its direction; an unacknowledged probe sets the error event.
- R7: A NACK on the address byte or on a written byte sets only status bit 13 and skips the remaining bytes. STOP is then issued even when bit 13 of the command is set.
- R8: With command bit 13 (hold) set and no NACK, no STOP is issued and SCL is left driven low. The following command starts with a repeated START.
- R9: Status bits 15:13 are sticky. Writing a 1 to one of them clears it; writing 0 leaves it unchanged.
- R10: While nothing stretches the clock, consecutive SCL rising edges are 4*QTR_DIV clock cycles apart.
- R11: After reset, both lines are released, status reads 0 and the read mailbox reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_drive_low | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
The bench builds the controller with QTR_DIV = 4, so one SCL bit takes 16 clocks and a full three-byte transfer fits in a few hundred cycles. At that rate dozens of randomized commands, mixing both directions, both lengths and probes, run alongside the directed address-NACK, data-NACK, hold-then-repeated-START and clear-on-write cases. The short divider also lets the exact SCL period be measured against 4*QTR_DIV without a long run.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;

  // Command word fields whose positions software depends on.
  localparam int CMD_WR_BIT    = 10;
  localparam int CMD_LEN_BIT   = 11;
  localparam int CMD_PROBE_BIT = 12;
  localparam int CMD_HOLD_BIT  = 13;
  localparam logic [1:0] MODE_NATIVE = 2'b10;

  // Event bit positions inside the status register.
  localparam int EV_ERR = 13;
  localparam int EV_TX  = 14;
  localparam int EV_RX  = 15;

  // Register addresses.
  localparam logic [1:0] RA_CMD  = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_WMB  = 2'd2;
  localparam logic [1:0] RA_RMB  = 2'd3;

  typedef struct packed {
    logic [6:0] addr;
    logic       wr;
    logic       two;
    logic       probe;
    logic       hold;
  } cmd_t;

  typedef enum logic [2:0] {S_IDLE, S_START, S_BIT, S_STOP, S_FIN} eng_st_e;

  function automatic cmd_t decode_cmd(input logic [15:0] w);
    cmd_t c;
    c.addr  = w[6:0];
    c.wr    = w[CMD_WR_BIT];
    c.two   = w[CMD_LEN_BIT];
    c.probe = w[CMD_PROBE_BIT];
    c.hold  = w[CMD_HOLD_BIT];
    return c;
  endfunction

  function automatic logic cmd_native(input logic [15:0] w);
    return w[15:14] == MODE_NATIVE;
  endfunction

  // Number of payload bytes after the address byte.
  function automatic logic [1:0] data_bytes(input cmd_t c);
    if (c.probe) return 2'd0;
    return c.two ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [7:0] addr_byte(input cmd_t c);
    return {c.addr, ~c.wr};
  endfunction

  // Returns {rx, tx, err} for a finished command.
  function automatic logic [2:0] done_events(input logic err, input logic wr);
    if (err) return 3'b001;
    return wr ? 3'b010 : 3'b100;
  endfunction

endpackage

// File: rtl/i2cm_qtick.sv
`timescale 1ns/1ps
module i2cm_qtick #(
  parameter int QTR_DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!en || tick)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R10: the counter never runs past its terminal value.
  p_cnt_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/i2cm_engine.sv
`timescale 1ns/1ps
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  cmd_t        cmd,
  input  logic [15:0] wmb,
  input  logic        tick,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_low,
  output logic        sda_low,
  output logic        busy,
  output logic        done,
  output logic        err_out,
  output logic [15:0] rx_data
);
  eng_st_e     st;
  logic [1:0]  q;
  logic [3:0]  bcnt;
  logic [1:0]  byt;
  logic [7:0]  sh;
  logic        ackbit;
  logic        err;
  cmd_t        c;
  logic [15:0] wmb_l;

  // Named internal events.
  logic       adv, tx_phase, last_byte, out_bit, byte_end, nack_seen;
  logic [1:0] nbytes;

  assign adv       = tick && !(q == 2'd2 && !scl_i);   // wait while SCL held low
  assign nbytes    = data_bytes(c);
  assign tx_phase  = (byt == 2'd0) || c.wr;
  assign last_byte = (byt == nbytes);
  assign out_bit   = (bcnt < 4'd8) ? (tx_phase ? sh[7] : 1'b1)
                                   : (tx_phase ? 1'b1 : last_byte);
  assign byte_end  = (st == S_BIT) && adv && (q == 2'd3) && (bcnt == 4'd8);
  assign nack_seen = byte_end && tx_phase && ackbit;

  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);
  assign err_out = err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; bcnt <= '0; byt <= '0; sh <= '0;
      ackbit <= 1'b0; err <= 1'b0; scl_low <= 1'b0; sda_low <= 1'b0;
      rx_data <= '0; c <= '0; wmb_l <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          c <= cmd; wmb_l <= wmb; err <= 1'b0; q <= '0; st <= S_START;
        end
        S_START: if (adv) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_low <= 1'b0;
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b1;
            2'd3: begin
              scl_low <= 1'b1; st <= S_BIT; bcnt <= '0; byt <= '0;
              sh <= addr_byte(c);
            end
          endcase
        end
        S_BIT: if (adv) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_low <= !out_bit;
            2'd1: scl_low <= 1'b0;
            2'd2: if (bcnt < 4'd8) sh <= {sh[6:0], sda_i};
                  else             ackbit <= sda_i;
            2'd3: begin
              scl_low <= 1'b1;
              if (bcnt != 4'd8) bcnt <= bcnt + 4'd1;
              else if (tx_phase && ackbit) begin
                err <= 1'b1; st <= S_STOP;
              end else begin
                if (!tx_phase) begin
                  if (byt == 2'd1) rx_data[7:0]  <= sh;
                  else             rx_data[15:8] <= sh;
                end
                if (last_byte) st <= c.hold ? S_FIN : S_STOP;
                else begin
                  byt  <= byt + 2'd1;
                  bcnt <= '0;
                  sh   <= (byt == 2'd0) ? wmb_l[7:0] : wmb_l[15:8];
                end
              end
            end
          endcase
        end
        S_STOP: if (adv) begin
          q <= q + 2'd1;
          unique case (q)
            2'd0: sda_low <= 1'b1;
            2'd1: scl_low <= 1'b0;
            2'd2: sda_low <= 1'b0;
            2'd3: st <= S_FIN;
          endcase
        end
        S_FIN: begin
          sda_low <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3: during data bits SDA only moves while SCL is driven low.
  p_sda_still_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BIT && $past(st == S_BIT) && !scl_low && $past(!scl_low)) |-> $stable(sda_low));

  // R7: a NACK in a master-transmit slot always leads to STOP.
  p_nack_to_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen |=> (st == S_STOP));

  // R8: a held, acknowledged final byte finishes without STOP.
  p_hold_no_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && last_byte && c.hold && !(tx_phase && ackbit)) |=> (st == S_FIN));

  // R11: an idle engine that was not holding never drives SDA.
  p_idle_sda_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $past(st == S_IDLE)) |-> !sda_low);

endmodule

// File: rtl/i2cm_regs.sv
`timescale 1ns/1ps
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        busy,
  input  logic        done,
  input  logic        err,
  input  logic [15:0] rx,
  output logic        start,
  output cmd_t        cmd,
  output logic [15:0] wmb
);
  logic [15:0] cmd_q;
  logic [2:0]  ev;       // {rx, tx, err}
  logic [2:0]  ev_set, ev_clr;
  logic        stat_wr;

  assign start   = we && (addr == RA_CMD) && !busy && cmd_native(wdata);
  assign cmd     = decode_cmd(wdata);
  assign stat_wr = we && (addr == RA_STAT);
  assign ev_clr  = stat_wr ? {wdata[EV_RX], wdata[EV_TX], wdata[EV_ERR]} : 3'b000;
  assign ev_set  = done ? done_events(err, cmd_q[CMD_WR_BIT]) : 3'b000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0; ev <= '0; wmb <= '0;
    end else begin
      if (start) cmd_q <= wdata;
      if (we && addr == RA_WMB) wmb <= wdata;
      ev <= (ev & ~ev_clr) | ev_set;
    end
  end

  always_comb begin
    unique case (addr)
      RA_CMD:  rdata = cmd_q;
      RA_STAT: rdata = {ev[2], ev[1], ev[0], 12'd0, busy};
      RA_WMB:  rdata = wmb;
      default: rdata = rx;
    endcase
  end

  // R2: busy only drops together with a raised event.
  p_busy_ends_with_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (ev != 3'b000));

  // R1: a foreign-mode command leaves the engine idle.
  p_bad_mode_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == RA_CMD && !busy && wdata[15:14] != MODE_NATIVE) |=> !busy);

  // R9: events hold their value without a status write or completion.
  p_ev_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !stat_wr) |=> $stable(ev));

  // R2: completion raises at most one event at a time.
  p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_set));

endmodule

// File: rtl/i2c_mbox_master.sv
`timescale 1ns/1ps
module i2c_mbox_master
  import i2cm_pkg::*;
#(
  parameter int QTR_DIV = 125
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_drive_low,
  output logic        sda_drive_low
);
  logic        start, busy, done, err, tick;
  cmd_t        cmd;
  logic [15:0] wmb, rx;

  i2cm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .done(done), .err(err), .rx(rx),
    .start(start), .cmd(cmd), .wmb(wmb)
  );

  i2cm_qtick #(.QTR_DIV(QTR_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
  );

  i2cm_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .wmb(wmb), .tick(tick),
    .scl_i(scl_i), .sda_i(sda_i), .scl_low(scl_drive_low), .sda_low(sda_drive_low),
    .busy(busy), .done(done), .err_out(err), .rx_data(rx)
  );

endmodule

// File: tb/tb_i2c_mbox_master.sv
`timescale 1ns/1ps
module tb_i2c_mbox_master;
  localparam int DIV = 4;
  localparam logic [6:0] SLV = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0, reg_rdata;
  logic scl_drive_low, sda_drive_low;
  logic scl_w, sda_w;
  logic slv_low = 1'b0;

  assign scl_w = ~scl_drive_low;
  assign sda_w = ~(sda_drive_low | slv_low);

  always #4 clk = ~clk;   // 125 MHz

  i2c_mbox_master #(.QTR_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_w), .sda_i(sda_w),
    .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // ---------------- target model ----------------
  int sst = 0, sbit = 0, ri = 0, wn = 0, mn = 0, start_cnt = 0, stop_cnt = 0;
  int nack_at = -1;
  bit force_nack = 1'b0, matched = 1'b0, rw = 1'b0, mack = 1'b0, armed = 1'b0;
  logic [7:0] ssh = 8'd0, txb = 8'd0, addr_log = 8'd0;
  logic [7:0] rbytes [2];
  logic [7:0] wlog [4];
  bit mack_log [2];
  realtime last_rise = 0, prev_rise = 0;

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    start_cnt++; sst = 1; sbit = 0; slv_low = 1'b0; armed = 1'b0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    stop_cnt++; sst = 0; slv_low = 1'b0;
  end
  always @(posedge scl_w) begin
    prev_rise = last_rise; last_rise = $realtime;
    if (sst != 0) begin
      armed = 1'b1;
      if (sbit < 8) ssh = {ssh[6:0], sda_w};
      else if (sst == 3) begin
        mack = !sda_w;
        if (mn < 2) mack_log[mn] = mack;
        mn++;
      end
    end
  end
  always @(negedge scl_w) if (sst != 0 && armed) begin
    sbit++;
    if (sbit == 8) begin
      if (sst == 1) begin
        addr_log = ssh; rw = ssh[0];
        matched = (ssh[7:1] == SLV) && !force_nack;
        slv_low = matched;
      end else if (sst == 2) begin
        if (wn < 4) wlog[wn] = ssh;
        slv_low = (wn != nack_at);
        wn++;
      end else slv_low = 1'b0;
    end else if (sbit == 9) begin
      sbit = 0;
      if (sst == 1) begin
        slv_low = 1'b0;
        if (!matched) sst = 0;
        else if (rw) begin sst = 3; ri = 0; txb = rbytes[0]; slv_low = !txb[7]; end
        else sst = 2;
      end else if (sst == 2) begin
        if (!slv_low) sst = 0;
        slv_low = 1'b0;
      end else begin
        if (mack) begin ri++; txb = rbytes[ri & 1]; slv_low = !txb[7]; end
        else begin sst = 0; slv_low = 1'b0; end
      end
    end else if (sst == 3) slv_low = !txb[7 - sbit];
  end

  // ---------------- helpers ----------------
  function automatic logic [15:0] mk_cmd(input logic [6:0] a, input bit wr, input bit two,
                                         input bit probe, input bit hold);
    return {2'b10, hold, probe, two, wr, 3'b000, a};
  endfunction

  function automatic logic [15:0] exp_ev(input bit err, input bit wr);
    if (err) return 16'h2000;
    return wr ? 16'h4000 : 16'h8000;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    int n = 0;
    do begin rd_reg(2'd1, s); n++; end while (s[0] && n < 20000);
  endtask

  task automatic clear_log();
    wn = 0; mn = 0; start_cnt = 0; stop_cnt = 0; nack_at = -1; force_nack = 1'b0;
  endtask

  task automatic issue(input logic [15:0] w, input logic [15:0] c);
    wr_reg(2'd1, 16'hE000);
    wr_reg(2'd2, w);
    wr_reg(2'd0, c);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] s, d;
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    rbytes[0] = 8'hA5; rbytes[1] = 8'h3C;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clear_log();

    // R11: reset state
    rd_reg(2'd1, s); check("R11", s, 16'h0000, "status after reset");
    rd_reg(2'd3, s); check("R11", s, 16'h0000, "read mailbox after reset");
    check("R11", {scl_drive_low, sda_drive_low}, 2'b00, "lines released");

    // R1: foreign mode ignored
    wr_reg(2'd0, mk_cmd(SLV, 1, 0, 0, 0) ^ 16'hC000);
    rd_reg(2'd1, s); check("R1", s, 16'h0000, "busy/events after bad mode");
    repeat (100) @(negedge clk);
    check("R1", start_cnt, 0, "no START after bad mode");

    // R2: busy visible, command while busy ignored
    clear_log();
    issue(16'h0011, mk_cmd(SLV, 1, 0, 0, 0));
    rd_reg(2'd1, s); check("R2", s, 16'h0001, "busy right after command");
    wr_reg(2'd0, mk_cmd(SLV, 1, 1, 0, 0));
    wait_idle();
    rd_reg(2'd1, s); check("R2", s, 16'h4000, "single event at end");
    repeat (200) @(negedge clk);
    check("R1", start_cnt, 1, "command during busy ignored");
    check("R4", wn, 1, "one byte written");

    // R10: SCL period (last two rises of the previous transfer)
    check("R10", int'(last_rise - prev_rise), 4 * DIV * 8, "SCL period ns");

    // R9: write-one-to-clear
    wr_reg(2'd1, 16'h0000); rd_reg(2'd1, s); check("R9", s, 16'h4000, "zero write keeps");
    wr_reg(2'd1, 16'h2000); rd_reg(2'd1, s); check("R9", s, 16'h4000, "other bit keeps");
    wr_reg(2'd1, 16'h4000); rd_reg(2'd1, s); check("R9", s, 16'h0000, "one clears");

    // Randomized mix (R3, R4, R5, R6)
    for (int i = 0; i < 30; i++) begin
      bit wr, two, probe;
      logic [15:0] w;
      wr = 1'($urandom); two = 1'($urandom); probe = ($urandom % 6) == 0;
      w = 16'($urandom);
      rbytes[0] = 8'($urandom); rbytes[1] = 8'($urandom);
      if (probe) rbytes[0][7] = 1'b1;
      clear_log();
      issue(w, mk_cmd(SLV, wr, two, probe, 0));
      wait_idle();
      rd_reg(2'd1, s); check(probe ? "R6" : (wr ? "R4" : "R5"), s, exp_ev(0, wr), "event");
      check("R3", addr_log, {SLV, !wr}, "address byte");
      check("R8", {start_cnt[7:0], stop_cnt[7:0]}, 16'h0101, "one START one STOP");
      if (probe) check("R6", wn + mn, 0, "no data on probe");
      else if (wr) begin
        check("R4", wn, two ? 2 : 1, "bytes written");
        check("R4", wlog[0], w[7:0], "first byte");
        if (two) check("R4", wlog[1], w[15:8], "second byte");
      end else begin
        rd_reg(2'd3, d);
        check("R5", d[7:0], rbytes[0], "first read byte");
        if (two) begin
          check("R5", d[15:8], rbytes[1], "second read byte");
          check("R5", {mack_log[0], mack_log[1]}, 2'b10, "ACK then NACK");
        end else check("R5", mack_log[0], 1'b0, "single byte NACK");
      end
    end

    // R6 / R7: absent target
    clear_log();
    issue(16'h0000, mk_cmd(7'h11, 0, 0, 1, 0));
    wait_idle();
    rd_reg(2'd1, s); check("R6", s, 16'h2000, "probe of absent target");

    // R7: address NACK with hold still stops
    clear_log();
    issue(16'h1234, mk_cmd(7'h22, 1, 1, 0, 1));
    wait_idle();
    rd_reg(2'd1, s); check("R7", s, 16'h2000, "address NACK event");
    check("R7", stop_cnt, 1, "STOP despite hold");
    check("R7", wn, 0, "no data after address NACK");

    // R7: data NACK on first of two
    clear_log(); nack_at = 0;
    issue(16'hBEEF, mk_cmd(SLV, 1, 1, 0, 0));
    wait_idle();
    rd_reg(2'd1, s); check("R7", s, 16'h2000, "data NACK event");
    check("R7", wn, 1, "second byte skipped");
    check("R7", stop_cnt, 1, "STOP after data NACK");

    // R8: hold then repeated START read
    clear_log(); rbytes[0] = 8'h5E; rbytes[1] = 8'hC3;
    issue(16'h0077, mk_cmd(SLV, 1, 0, 0, 1));
    wait_idle();
    check("R8", stop_cnt, 0, "no STOP on hold");
    check("R8", scl_drive_low, 1'b1, "SCL kept low");
    rd_reg(2'd1, s); check("R8", s, 16'h4000, "held write event");
    issue(16'h0000, mk_cmd(SLV, 0, 1, 0, 0));
    wait_idle();
    check("R8", {start_cnt[7:0], stop_cnt[7:0]}, 16'h0201, "repeated START then STOP");
    rd_reg(2'd3, d); check("R5", d, 16'hC35E, "read after repeated START");
    check("R11", {scl_drive_low, sda_drive_low}, 2'b00, "lines free after STOP");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule